// File: doc/BRIEF.md
# Multi-channel timer with compare and capture interrupts

The block is a 16-bit free-running timer for a register-mapped peripheral space. The timer advances on ticks from one of four selectable tick inputs. Each tick first passes through a power-of-two divider stage and then through a divide-by-1-to-8 stage. While the timer runs, every channel either raises its flag when the count steps onto its compare value, or stores the count when its capture input rises.

Channel 0 has its own interrupt line. The overflow flag and channels 1 and up share a second line. Software reads a vector register to learn which source on the shared line is pending, and that read clears the source it returns. Software controls the block through a write port that takes effect in one cycle and a read port whose data is combinational.

Top module: `tick_timer`

Word address map: 0 control, 1 extended divider, 2 count, 3 vector. Channel n uses address 4+2n for its control register and 5+2n for its compare/capture register.

## Requirements
- R1: After reset, every register reads 0 and both interrupt outputs are low.
- R2: With divider field d (control bits 7:6) and extended field e (extended-divider register bits 2:0), counting starts from a clear. After N selected ticks, the count reads N / (2^d × (e+1)), rounded down.
- R3: Clock-source field s (control bits 9:8) selects `src_tick_i[s]`, and code 2 is the subsystem clock tick. Ticks on the other three inputs have no effect on the count.
- R4: Mode field code 2 (control bits 5:4) counts continuously. A divided tick at 0xFFFF wraps the count to 0 and sets the overflow flag (control bit 0).
- R5: Mode field code 0 stops counting, and the count holds regardless of ticks.
- R6: Writing 1 to control bit 2 zeroes the count and both divider stages. The bit always reads back 0.
- R7: A channel in compare mode (channel control bit 8 = 0) sets its flag (channel control bit 0) on the divided tick that moves the count onto its compare value. The flag is not set again while the count stays there.
- R8: A channel in capture mode (channel control bit 8 = 1) copies the count into its compare/capture register and sets its flag on a rising edge of its `cap_i` bit.
- R9: `irq_ch0_o` is high exactly while channel 0 has its flag and its enable (channel control bit 4) both set. Channel 0 never appears on the shared line or in the vector.
- R10: A source is pending when its flag and enable are both set; for overflow the enable is control bit 1. `irq_shared_o` is high while any of channels 1 and up, or overflow, is pending. The vector reads 2n for the lowest-numbered pending channel n ≥ 1, else 2×NCH if overflow is pending, else 0.
- R11: Reading the vector register clears the flag of the source it reports and no other flag.
- R12: A write to the count register loads the count. A write to a flag bit stores the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_tick_i | input | 4 | Tick inputs, selected by the clock-source field |
| cap_i | input | NCH | Capture event inputs, one per channel |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe (has side effects only on the vector) |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | CNT_W | Write data |
| bus_rdata_o | output | CNT_W | Read data for the addressed register |
| irq_ch0_o | output | 1 | Channel 0 interrupt |
| irq_shared_o | output | 1 | Overflow and channel 1..NCH-1 interrupt |

## Verification
The bench builds the block with NCH = 4 and ADDR_W = 4. With those values the vector arbitrates three channels, the overflow code is 8, and every channel register sits inside the 4-bit address space. The 16-bit count is kept, and bus loads of 0xFFFE reach the wrap within two ticks. Random divider and extended-divider settings are combined with exact tick counts to cover the whole cascade range. Noise on the unselected tick inputs shows that source selection isolates them.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADR_CTRL    = 0;
  localparam int ADR_EXT     = 1;
  localparam int ADR_CNT     = 2;
  localparam int ADR_VEC     = 3;
  localparam int ADR_CH_BASE = 4;

  localparam logic [1:0] MODE_STOP = 2'b00;
  localparam logic [1:0] MODE_CONT = 2'b10;

  localparam int DIV_W = 2;
  localparam int EXT_W = 3;

  localparam int B_OVFLAG = 0;
  localparam int B_OVIE   = 1;
  localparam int B_CLR    = 2;
  localparam int B_CH_FLG = 0;
  localparam int B_CH_IE  = 4;
  localparam int B_CH_CAP = 8;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [EXT_W-1:0] ext_i,
  output logic             tick_o
);
  localparam int C1_W = (1 << DIV_W) - 1;

  logic [C1_W-1:0]  c1_q, lim1;
  logic [EXT_W-1:0] c2_q;
  logic             s1_tick;

  always_comb lim1 = C1_W'((32'd1 << div_i) - 32'd1);

  assign s1_tick = run_i & tick_i & (c1_q >= lim1);
  assign tick_o  = s1_tick & (c2_q >= ext_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c1_q <= '0;
      c2_q <= '0;
    end else if (clr_i) begin
      c1_q <= '0;
      c2_q <= '0;
    end else begin
      if (run_i && tick_i) c1_q <= s1_tick ? '0 : c1_q + 1'b1;
      if (s1_tick)         c2_q <= tick_o ? '0 : c2_q + 1'b1;
    end
  end

  // back-to-back outputs only when both stages divide by one
  AST_PS_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (!tick_o || (div_i == '0 && ext_i == '0))); // R2
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic             adv_i,
  input  logic             cap_i,
  input  logic             ctl_we_i,
  input  logic             ccr_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             vec_clr_i,
  output logic [CNT_W-1:0] ccr_o,
  output logic [CNT_W-1:0] ctl_o,
  output logic             pend_o
);
  logic             cap_mode_q, ie_q, flag_q, cap_q;
  logic [CNT_W-1:0] ccr_q;
  logic             cap_evt, cmp_hit;

  assign cap_evt = cap_mode_q & cap_i & ~cap_q;
  assign cmp_hit = ~cap_mode_q & adv_i & (cnt_nxt_i == ccr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_mode_q <= 1'b0;
      ie_q       <= 1'b0;
      flag_q     <= 1'b0;
      cap_q      <= 1'b0;
      ccr_q      <= '0;
    end else begin
      cap_q <= cap_i;
      if (ctl_we_i) begin
        cap_mode_q <= wdata_i[B_CH_CAP];
        ie_q       <= wdata_i[B_CH_IE];
      end
      if (cap_evt || cmp_hit) flag_q <= 1'b1;
      else if (ctl_we_i)      flag_q <= wdata_i[B_CH_FLG];
      else if (vec_clr_i)     flag_q <= 1'b0;
      if (cap_evt)            ccr_q <= cnt_i;
      else if (ccr_we_i)      ccr_q <= wdata_i;
    end
  end

  always_comb begin
    ctl_o           = '0;
    ctl_o[B_CH_CAP] = cap_mode_q;
    ctl_o[B_CH_IE]  = ie_q;
    ctl_o[B_CH_FLG] = flag_q;
  end

  assign ccr_o  = ccr_q;
  assign pend_o = flag_q & ie_q;

  AST_CAP_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt |=> (ccr_q == $past(cnt_i) && flag_q)); // R8
  AST_CMP_NO_REFIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_mode_q && !adv_i && !ctl_we_i) |=> !$rose(flag_q)); // R7
endmodule

// File: rtl/tmr_irq_vec.sv
module tmr_irq_vec #(
  parameter int NCH   = 7,
  parameter int CNT_W = 16
) (
  input  logic [NCH-1:0]   pend_i,
  input  logic             ov_pend_i,
  input  logic             rd_i,
  output logic             irq0_o,
  output logic             irq_sh_o,
  output logic [CNT_W-1:0] vec_o,
  output logic [NCH-1:0]   ch_clr_o,
  output logic             ov_clr_o
);
  logic found;

  always_comb begin
    found    = 1'b0;
    vec_o    = '0;
    ch_clr_o = '0;
    ov_clr_o = 1'b0;
    for (int n = 1; n < NCH; n++) begin
      if (pend_i[n] && !found) begin
        found       = 1'b1;
        vec_o       = CNT_W'(2 * n);
        ch_clr_o[n] = rd_i;
      end
    end
    if (!found && ov_pend_i) begin
      vec_o    = CNT_W'(2 * NCH);
      ov_clr_o = rd_i;
    end
  end

  assign irq0_o   = pend_i[0];
  assign irq_sh_o = (|pend_i[NCH-1:1]) | ov_pend_i;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tmr_pkg::*;
#(
  parameter int NCH    = 7,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        src_tick_i,
  input  logic [NCH-1:0]    cap_i,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  output logic              irq_ch0_o,
  output logic              irq_shared_o
);
  logic [1:0]       src_q, mode_q;
  logic [DIV_W-1:0] div_q;
  logic [EXT_W-1:0] ext_q;
  logic             ovie_q, ovflag_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  logic ctrl_we, ext_we, cnt_we, vec_rd, clr, run, ps_tick, adv;
  logic ov_clr;
  logic [CNT_W-1:0] vec;
  logic [NCH-1:0]   ch_pend, ch_clr, ch_ctl_we, ch_ccr_we;
  logic [CNT_W-1:0] ch_ctl [NCH];
  logic [CNT_W-1:0] ch_ccr [NCH];

  assign ctrl_we = bus_we_i & (bus_addr_i == ADDR_W'(ADR_CTRL));
  assign ext_we  = bus_we_i & (bus_addr_i == ADDR_W'(ADR_EXT));
  assign cnt_we  = bus_we_i & (bus_addr_i == ADDR_W'(ADR_CNT));
  assign vec_rd  = bus_re_i & (bus_addr_i == ADDR_W'(ADR_VEC));
  assign clr     = ctrl_we & bus_wdata_i[B_CLR];
  assign run     = (mode_q == MODE_CONT);
  assign adv     = ps_tick & ~cnt_we & ~clr;
  assign cnt_nxt = cnt_q + 1'b1;

  tmr_prescaler u_ps (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .run_i  (run),
    .tick_i (src_tick_i[src_q]),
    .div_i  (div_q),
    .ext_i  (ext_q),
    .tick_o (ps_tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q    <= '0;
      div_q    <= '0;
      mode_q   <= MODE_STOP;
      ovie_q   <= 1'b0;
      ovflag_q <= 1'b0;
      ext_q    <= '0;
      cnt_q    <= '0;
    end else begin
      if (ctrl_we) begin
        src_q  <= bus_wdata_i[9:8];
        div_q  <= bus_wdata_i[7:6];
        mode_q <= bus_wdata_i[5:4];
        ovie_q <= bus_wdata_i[B_OVIE];
      end
      if (ext_we) ext_q <= bus_wdata_i[EXT_W-1:0];
      if (adv && cnt_q == '1) ovflag_q <= 1'b1;
      else if (ctrl_we)       ovflag_q <= bus_wdata_i[B_OVFLAG];
      else if (ov_clr)        ovflag_q <= 1'b0;
      if (clr)         cnt_q <= '0;
      else if (cnt_we) cnt_q <= bus_wdata_i;
      else if (adv)    cnt_q <= cnt_nxt;
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign ch_ctl_we[n] = bus_we_i & (bus_addr_i == ADDR_W'(ADR_CH_BASE + 2 * n));
    assign ch_ccr_we[n] = bus_we_i & (bus_addr_i == ADDR_W'(ADR_CH_BASE + 2 * n + 1));
    tmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cnt_i     (cnt_q),
      .cnt_nxt_i (cnt_nxt),
      .adv_i     (adv),
      .cap_i     (cap_i[n]),
      .ctl_we_i  (ch_ctl_we[n]),
      .ccr_we_i  (ch_ccr_we[n]),
      .wdata_i   (bus_wdata_i),
      .vec_clr_i (ch_clr[n]),
      .ccr_o     (ch_ccr[n]),
      .ctl_o     (ch_ctl[n]),
      .pend_o    (ch_pend[n])
    );
  end

  tmr_irq_vec #(.NCH(NCH), .CNT_W(CNT_W)) u_vec (
    .pend_i    (ch_pend),
    .ov_pend_i (ovflag_q & ovie_q),
    .rd_i      (vec_rd),
    .irq0_o    (irq_ch0_o),
    .irq_sh_o  (irq_shared_o),
    .vec_o     (vec),
    .ch_clr_o  (ch_clr),
    .ov_clr_o  (ov_clr)
  );

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      ADDR_W'(ADR_CTRL): begin
        bus_rdata_o[9:8]      = src_q;
        bus_rdata_o[7:6]      = div_q;
        bus_rdata_o[5:4]      = mode_q;
        bus_rdata_o[B_OVIE]   = ovie_q;
        bus_rdata_o[B_OVFLAG] = ovflag_q;
      end
      ADDR_W'(ADR_EXT): bus_rdata_o[EXT_W-1:0] = ext_q;
      ADDR_W'(ADR_CNT): bus_rdata_o = cnt_q;
      ADDR_W'(ADR_VEC): bus_rdata_o = vec;
      default: begin
        for (int n = 0; n < NCH; n++) begin
          if (bus_addr_i == ADDR_W'(ADR_CH_BASE + 2 * n))     bus_rdata_o = ch_ctl[n];
          if (bus_addr_i == ADDR_W'(ADR_CH_BASE + 2 * n + 1)) bus_rdata_o = ch_ccr[n];
        end
      end
    endcase
  end

  AST_WRAP_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && cnt_q == '1) |=> (ovflag_q && cnt_q == '0)); // R4
  AST_STOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != MODE_CONT && !cnt_we && !clr) |=> $stable(cnt_q)); // R5
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (cnt_q == '0)); // R6
  AST_CNT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_we && !clr) |=> (cnt_q == $past(bus_wdata_i))); // R12
  AST_SHARED_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_shared_o |-> (vec != '0)); // R10
endmodule

// File: tb/sim_tick_timer.sv
module sim_tick_timer;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int AW  = 4;
  localparam int A_CTRL = 0, A_EXT = 1, A_CNT = 2, A_VEC = 3;
  localparam int OV_CODE = 2 * NCH;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] src_tick = '0;
  logic [NCH-1:0] cap = '0;
  logic we = 1'b0, re = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic irq0, irqs;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tick_timer #(.NCH(NCH), .CNT_W(16), .ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_tick_i(src_tick), .cap_i(cap),
    .bus_we_i(we), .bus_re_i(re), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_ch0_o(irq0), .irq_shared_o(irqs));

  function automatic logic [15:0] ctrl_word(int s, int d, int m, bit ie, bit fl, bit cl);
    return 16'((s << 8) | (d << 6) | (m << 4) | (int'(cl) << 2) | (int'(ie) << 1) | int'(fl));
  endfunction
  function automatic int ch_ctl_adr(int n); return 4 + 2 * n; endfunction
  function automatic int ch_ccr_adr(int n); return 5 + 2 * n; endfunction
  function automatic int div_total(int d, int e); return (1 << d) * (e + 1); endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(int a, output logic [15:0] d);
    @(negedge clk); re = 1'b1; addr = AW'(a);
    #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic pulse(int b, int n);
    logic [3:0] t;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); t = 4'($urandom); t[b] = 1'b1; src_tick = t;
      @(negedge clk); t = 4'($urandom); t[b] = 1'b0; src_tick = t;
    end
    @(negedge clk); src_tick = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int d, e, n;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_CTRL, v); chk("R1 ctrl", v, 16'h0);
    rd(A_CNT, v);  chk("R1 cnt", v, 16'h0);
    rd(A_VEC, v);  chk("R1 vec", v, 16'h0);
    rd(ch_ctl_adr(1), v); chk("R1 ch1 ctl", v, 16'h0);
    chk("R1 irqs", {14'h0, irq0, irqs}, 16'h0);

    // R2 random cascade division, R3 noise on other sources
    for (int k = 0; k < 10; k++) begin
      d = int'($urandom % 4); e = int'($urandom % 8); n = int'($urandom % 150) + 1;
      if (k == 0) begin d = 3; e = 1; n = 40; end
      wr(A_EXT, 16'(e));
      wr(A_CTRL, ctrl_word(2, d, 2, 0, 0, 1));
      pulse(2, n);
      rd(A_CNT, v); chk("R2 divided count", v, 16'(n / div_total(d, e)));
    end

    // R3 alternate source
    wr(A_EXT, 16'h0);
    wr(A_CTRL, ctrl_word(1, 0, 2, 0, 0, 1));
    pulse(1, 7);
    rd(A_CNT, v); chk("R3 source 1 count", v, 16'd7);

    // R6 clear resets divider state, clear bit reads 0
    wr(A_CTRL, ctrl_word(2, 1, 2, 0, 0, 1));
    pulse(2, 1);
    wr(A_CTRL, ctrl_word(2, 1, 2, 0, 0, 1));
    rd(A_CTRL, v); chk("R6 clr reads 0", v, ctrl_word(2, 1, 2, 0, 0, 0));
    pulse(2, 1);
    rd(A_CNT, v); chk("R6 divider restarted", v, 16'd0);
    pulse(2, 1);
    rd(A_CNT, v); chk("R6 after two ticks", v, 16'd1);

    // R4 wrap and overflow, R10/R11 vector
    wr(A_CTRL, ctrl_word(2, 0, 2, 1, 0, 1));
    wr(A_CNT, 16'hFFFE);
    pulse(2, 1);
    rd(A_CNT, v);  chk("R4 at max", v, 16'hFFFF);
    rd(A_CTRL, v); chk("R4 flag not yet", v & 16'h1, 16'h0);
    pulse(2, 1);
    rd(A_CNT, v);  chk("R4 wrapped", v, 16'h0);
    rd(A_CTRL, v); chk("R4 flag set", v & 16'h1, 16'h1);
    chk("R10 shared irq on overflow", {15'h0, irqs}, 16'h1);
    rd(A_VEC, v);  chk("R10 overflow code", v, 16'(OV_CODE));
    rd(A_VEC, v);  chk("R11 vec cleared", v, 16'h0);
    rd(A_CTRL, v); chk("R11 ov flag cleared", v & 16'h1, 16'h0);
    chk("R11 shared irq low", {15'h0, irqs}, 16'h0);

    // R5 stop mode
    wr(A_CTRL, ctrl_word(2, 0, 0, 0, 0, 0));
    wr(A_CNT, 16'h1234);
    pulse(2, 5);
    rd(A_CNT, v); chk("R5 held", v, 16'h1234);

    // R7 compare on change only, R9 channel 0 routing
    wr(A_CTRL, ctrl_word(2, 0, 2, 0, 0, 1));
    wr(ch_ctl_adr(1), 16'h0010);
    wr(ch_ccr_adr(1), 16'd5);
    wr(A_CNT, 16'd3);
    pulse(2, 1);
    rd(ch_ctl_adr(1), v); chk("R7 no flag before match", v & 16'h1, 16'h0);
    pulse(2, 1);
    rd(ch_ctl_adr(1), v); chk("R7 flag at match", v & 16'h1, 16'h1);
    chk("R10 shared irq ch1", {14'h0, irq0, irqs}, 16'h1);
    wr(ch_ctl_adr(1), 16'h0010);
    repeat (5) @(negedge clk);
    rd(ch_ctl_adr(1), v); chk("R7 no refire while equal", v & 16'h1, 16'h0);
    wr(ch_ctl_adr(0), 16'h0010);
    wr(ch_ccr_adr(0), 16'd7);
    pulse(2, 2);
    chk("R9 ch0 line only", {14'h0, irq0, irqs}, 16'h2);
    rd(A_VEC, v); chk("R9 ch0 not in vector", v, 16'h0);
    wr(ch_ctl_adr(0), 16'h0000);
    chk("R12 flag write clears ch0", {15'h0, irq0}, 16'h0);

    // R10 priority, R11 one flag per read
    wr(A_CTRL, ctrl_word(2, 0, 2, 1, 1, 0));
    wr(ch_ctl_adr(3), 16'h0010);
    wr(ch_ccr_adr(3), 16'd10);
    wr(ch_ccr_adr(1), 16'd10);
    wr(ch_ctl_adr(2), 16'h0000);
    wr(ch_ccr_adr(2), 16'd10);
    wr(A_CNT, 16'd9);
    pulse(2, 1);
    rd(A_VEC, v); chk("R10 ch1 first", v, 16'd2);
    rd(A_VEC, v); chk("R10 ch3 next", v, 16'd6);
    rd(A_VEC, v); chk("R10 overflow last", v, 16'(OV_CODE));
    rd(A_VEC, v); chk("R11 all reported cleared", v, 16'h0);
    rd(ch_ctl_adr(2), v); chk("R10 unenabled flag kept", v & 16'h1, 16'h1);
    chk("R10 shared irq idle", {15'h0, irqs}, 16'h0);

    // R8 capture
    wr(A_CTRL, ctrl_word(2, 0, 0, 0, 0, 0));
    wr(A_CNT, 16'hBEEF);
    wr(ch_ctl_adr(2), 16'h0110);
    @(negedge clk); cap[2] = 1'b1;
    @(negedge clk); cap[2] = 1'b0;
    rd(ch_ccr_adr(2), v); chk("R8 captured", v, 16'hBEEF);
    rd(ch_ctl_adr(2), v); chk("R8 flag", v & 16'h1, 16'h1);
    rd(A_VEC, v); chk("R8 vector ch2", v, 16'd4);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule